// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash device. Once software or a sequencer has sent a program or erase command, a start request gives the poller three things: the kind of operation, the address to watch, and the word that should be there at the end. The poller then reads that address over a simple synchronous read port. Only one read is in flight at any time. It reads the status bit 7 of each returned word until the device reports that the operation has finished, and then it ends with exactly one outcome: success, data error, or timeout.

For a program, bit 7 reads back as the inverse of the intended bit 7 while the device is busy. It reads back as the true bit once the program is finished. For an erase, bit 7 reads 0 while the device is busy and 1 once it is finished. The word that first shows completion on bit 7 can still carry stale values in bits 6 to 0. For that reason the poller always issues one more read and judges the whole word from that read. A device that is asked to write to a protected region can report misleading status. A cycle-count limit therefore bounds every operation.

Top module: `flash_poll_checker`

## Requirements
- R1: After reset, busy_o, rd_req_o, done_o, error_o and timeout_o are all 0.
- R2: When start_i is high and the block is idle, it latches op_erase_i, addr_i, data_i and limit_i. It raises busy_o and rd_req_o in the next cycle. Every read of that operation uses the latched address on rd_addr_o.
- R3: rd_req_o is a one-cycle pulse, and no new request is issued while a read is outstanding. If the operation continues after a response (rd_valid_i high), the next rd_req_o comes in the cycle directly after it. With a response latency of L cycles, each read therefore takes L+1 cycles.
- R4: For a program (op_erase_i=0), a response whose bit 7 differs from bit 7 of the expected word means busy, and polling goes on. A response whose bit 7 equals it means the program is complete.
- R5: For an erase (op_erase_i=1), a response with bit 7 equal to 0 means busy, and a response with bit 7 equal to 1 means complete.
- R6: Once bit 7 shows completion, exactly one more read is issued. Bits 6 to 0 of the completing response are ignored. The whole word of the additional read is judged, so an operation with B busy responses makes exactly B+2 reads.
- R7: If the additional read returns the expected word, done_o pulses for one cycle, in the cycle after that response. For a program the expected word is the start data; for an erase it is all ones.
- R8: If the additional read differs from the expected word in any bit, error_o pulses for one cycle in place of done_o.
- R9: Count the start cycle as cycle 0. If the final response has not arrived by cycle limit+1, timeout_o pulses in cycle limit+2, and a response arriving in cycle limit+1 is discarded.
- R10: A start_i pulse while busy_o is high has no effect: the read address and the outcome are unchanged.
- R11: done_o, error_o and timeout_o are never high together. Each one is a single-cycle pulse, and busy_o is low in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| addr_i | input | AW | Address to poll |
| data_i | input | DW | Expected word for a program |
| limit_i | input | TW | Timeout limit in cycles |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completed with matching word (pulse) |
| error_o | output | 1 | Completed with mismatching word (pulse) |
| timeout_o | output | 1 | Limit expired before completion (pulse) |

## Verification
The bound checker watches the read-port rules on every cycle: the single outstanding read, the request that follows each response, and the address held steady while busy. It also checks that the three outcomes exclude each other, that a result always follows a response, and that no operation stays busy past its latched limit.

Some properties depend on the device's data sequence, so only the bench scenarios can show them. These are the busy/complete decoding of bit 7 for each operation, the extra confirming read that skips the partly stale completing word, the choice between done and error, and the exact cycle at which a timeout beats a late final response. The bench sweeps response latency, busy-read count, expected bit 7 polarity and corruption for both operations, and it runs limits on both sides of the completion cycle.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    // Position of the completion status bit inside a returned word.
    localparam int unsigned STATUS_BIT = 7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

endpackage

// File: rtl/fpoll_judge.sv
// Decodes the status bit of one response into "operation complete".
module fpoll_judge (
    input  logic is_erase,
    input  logic exp_bit,
    input  logic rd_bit,
    output logic complete
);
    always_comb begin
        if (is_erase) complete = rd_bit;
        else          complete = (rd_bit == exp_bit);
    end
endmodule

// File: rtl/fpoll_cmp.sv
// Whole-word comparison of the confirming read against the expected word.
module fpoll_cmp #(
    parameter int unsigned DW = 32
) (
    input  logic          is_erase,
    input  logic [DW-1:0] exp_word,
    input  logic [DW-1:0] rd_word,
    output logic          mismatch
);
    logic [DW-1:0] diff;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic ref_bit;
        assign ref_bit = is_erase ? 1'b1 : exp_word[i];
        assign diff[i] = rd_word[i] ^ ref_bit;
    end

    assign mismatch = |diff;
endmodule

// File: rtl/fpoll_timer.sv
// Counts busy cycles; flags expiry when the count reaches the limit.
module fpoll_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] elapsed_d, elapsed_q;

    assign expired = run && (elapsed_q == limit);

    always_comb begin
        if (!run)         elapsed_d = '0;
        else if (expired) elapsed_d = elapsed_q;
        else              elapsed_d = elapsed_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elapsed_q <= '0;
        else        elapsed_q <= elapsed_d;
    end
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
    import fpoll_pkg::*;
#(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 32,
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [TW-1:0] limit_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o,
    output logic          timeout_o
);
    typedef struct packed {
        phase_e        phase;
        logic          erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] expd;
        logic [TW-1:0] limit;
        logic          confirm;
        logic          done;
        logic          err;
        logic          tmo;
    } ctl_t;

    ctl_t q, d;
    logic busy;
    logic complete;
    logic mismatch;
    logic expired;

    assign busy = (q.phase != PH_IDLE);

    fpoll_judge u_judge (
        .is_erase (q.erase),
        .exp_bit  (q.expd[STATUS_BIT]),
        .rd_bit   (rd_data_i[STATUS_BIT]),
        .complete (complete)
    );

    fpoll_cmp #(.DW(DW)) u_cmp (
        .is_erase (q.erase),
        .exp_word (q.expd),
        .rd_word  (rd_data_i),
        .mismatch (mismatch)
    );

    fpoll_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .limit   (q.limit),
        .expired (expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        d.tmo  = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase   = PH_ISSUE;
                    d.erase   = op_erase_i;
                    d.addr    = addr_i;
                    d.expd    = data_i;
                    d.limit   = limit_i;
                    d.confirm = 1'b0;
                end
            end
            PH_ISSUE: d.phase = PH_WAIT;
            PH_WAIT: begin
                if (rd_valid_i) begin
                    if (q.confirm) begin
                        d.phase   = PH_IDLE;
                        d.confirm = 1'b0;
                        d.done    = !mismatch;
                        d.err     = mismatch;
                    end else begin
                        d.phase   = PH_ISSUE;
                        d.confirm = complete;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
        if (busy && expired) begin
            d.phase   = PH_IDLE;
            d.confirm = 1'b0;
            d.done    = 1'b0;
            d.err     = 1'b0;
            d.tmo     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_o  = (q.phase == PH_ISSUE);
    assign rd_addr_o = q.addr;
    assign busy_o    = busy;
    assign done_o    = q.done;
    assign error_o   = q.err;
    assign timeout_o = q.tmo;

endmodule

// File: rtl/fpoll_sva.sv
module fpoll_sva #(
    parameter int unsigned AW = 20,
    parameter int unsigned TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [TW-1:0] limit_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_valid_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          error_o,
    input logic          timeout_o
);
    logic          outstanding_q;
    logic [TW:0]   cnt_q;
    logic [TW-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
            cnt_q         <= '0;
            lim_q         <= '0;
        end else if (!busy_o) begin
            outstanding_q <= 1'b0;
            cnt_q         <= '0;
            if (start_i) lim_q <= limit_i;
        end else begin
            if (rd_req_o)        outstanding_q <= 1'b1;
            else if (rd_valid_i) outstanding_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy_o) && $past(start_i)) |-> (busy_o && rd_req_o)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (rd_addr_o == $past(rd_addr_o))); // R10
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !outstanding_q); // R3
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o); // R3
    AST_REQ_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_valid_i && outstanding_q) && busy_o) |-> rd_req_o); // R3
    AST_RESULT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> $past(rd_valid_i)); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, error_o, timeout_o})); // R11
    AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o || timeout_o) |=> !(done_o || error_o || timeout_o)); // R11
    AST_IDLE_AT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o || timeout_o) |-> !busy_o); // R11
    AST_BUSY_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= {1'b0, lim_q})); // R9
    AST_TMO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (cnt_q == ({1'b0, lim_q} + 1'b1))); // R9

endmodule

bind flash_poll_checker fpoll_sva #(.AW(AW), .TW(TW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .limit_i    (limit_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .timeout_o  (timeout_o)
);

// File: tb/flash_poll_checker_tb.sv
module flash_poll_checker_tb;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic [TW-1:0] limit_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o, done_o, error_o, timeout_o;

    always #4 clk = ~clk;

    flash_poll_checker #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .addr_i(addr_i), .data_i(data_i), .limit_i(limit_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .timeout_o(timeout_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Device model state
    bit            m_erase;
    logic [DW-1:0] m_exp;
    logic [AW-1:0] m_addr;
    int            m_nb, m_lat, m_idx, m_cnt;
    bit            m_corrupt, m_pend;
    int            n_req, n_overlap, n_badaddr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] final_word();
        logic [DW-1:0] w;
        w = m_erase ? '1 : m_exp;
        if (m_corrupt) w[0] = ~w[0];
        return w;
    endfunction

    function automatic logic [DW-1:0] word_at(input int idx);
        logic [DW-1:0] w;
        w = final_word();
        if (idx < m_nb) begin
            w[6:0] = w[6:0] ^ 7'h2A;
            w[7]   = m_erase ? 1'b0 : ~m_exp[7];
        end else if (idx == m_nb) begin
            w[6:0] = ~w[6:0];     // status bit final, low bits still stale
        end
        return w;
    endfunction

    // Responder: acts at falling edges, away from the active edge.
    always @(negedge clk) begin
        rd_valid_i = 1'b0;
        if (m_pend) begin
            if (m_cnt <= 1) begin
                rd_valid_i = 1'b1;
                rd_data_i  = word_at(m_idx);
                m_idx++;
                m_pend = 0;
            end else begin
                m_cnt--;
            end
        end
        if (rd_req_o) begin
            if (m_pend) n_overlap++;
            if (rd_addr_o != m_addr) n_badaddr++;
            n_req++;
            m_pend = 1;
            m_cnt  = m_lat;
        end
    end

    // Outcome codes: 0 none, 1 done, 2 error, 3 timeout
    task automatic run_op(input bit erase, input int lat, input int nb, input bit corrupt,
                          input int limit, input bit inject, input logic [DW-1:0] expw);
        int k, outc, exp_out, exp_k, reads, span;
        m_erase = erase; m_exp = expw; m_nb = nb; m_lat = lat; m_corrupt = corrupt;
        m_idx = 0; m_addr = AW'(20'h3_0000 + (nb * 16 + lat * 4));
        n_req = 0; n_overlap = 0; n_badaddr = 0;
        @(negedge clk);
        start_i = 1'b1; op_erase_i = erase; addr_i = m_addr; data_i = expw;
        limit_i = TW'(limit);
        k = 0; outc = 0;
        while (k < 6000) begin
            @(negedge clk);
            k++;
            start_i = inject && (k == 3);
            if (k == 3) begin addr_i = ~m_addr; data_i = ~expw; op_erase_i = ~erase; limit_i = 2; end
            if (done_o)    outc = 1;
            if (error_o)   outc = 2;
            if (timeout_o) outc = 3;
            if (outc != 0) break;
        end
        reads = nb + 2;
        span  = reads * (lat + 1);
        if (limit + 1 <= span) begin exp_out = 3; exp_k = limit + 2; end
        else begin exp_out = corrupt ? 2 : 1; exp_k = span + 1; end
        if (exp_out == 3)      chk(outc == exp_out, "R9 timeout outcome", outc, exp_out);
        else if (erase)        chk(outc == exp_out, corrupt ? "R8 erase mismatch" : "R5 R7 erase done", outc, exp_out);
        else                   chk(outc == exp_out, corrupt ? "R8 program mismatch" : "R4 R7 program done", outc, exp_out);
        chk(k == exp_k, exp_out == 3 ? "R9 timeout cycle" : "R3 R6 completion cycle", k, exp_k);
        if (exp_out != 3) chk(n_req == reads, "R6 read count", n_req, reads);
        chk(n_overlap == 0, "R3 one outstanding read", n_overlap, 0);
        chk(n_badaddr == 0, inject ? "R10 start ignored, address kept" : "R2 read address", n_badaddr, 0);
        @(negedge clk);
        chk(!(done_o || error_o || timeout_o || busy_o), "R11 single-cycle outcome",
            {busy_o, done_o, error_o, timeout_o}, 0);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pend = 0; m_cnt = 0; m_idx = 0; m_nb = 0; m_lat = 1; m_erase = 0; m_exp = '0;
        m_corrupt = 0; m_addr = '0; n_req = 0; n_overlap = 0; n_badaddr = 0;
        repeat (3) @(negedge clk);
        chk(!(busy_o || rd_req_o || done_o || error_o || timeout_o), "R1 reset outputs",
            {busy_o, rd_req_o, done_o, error_o, timeout_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(busy_o || rd_req_o || done_o || error_o || timeout_o), "R1 idle after reset",
            {busy_o, rd_req_o, done_o, error_o, timeout_o}, 0);

        for (int op = 0; op < 2; op++)
            for (int lat = 1; lat <= 3; lat++)
                for (int nb = 0; nb <= 3; nb += (nb == 0 ? 1 : 2))
                    for (int c = 0; c < 2; c++)
                        run_op(op[0], lat, nb, c[0], 1000, (lat == 2),
                               32'hA5C3_1E00 ^ DW'((lat * 97 + nb * 13 + c) << 8) ^ DW'((nb + c) % 2 << 7) ^ 32'h0000_0055);

        // Timeout boundary for a program: 4 reads, latency 2 -> span 12
        for (int lim = 9; lim <= 12; lim++)
            run_op(1'b0, 2, 2, 1'b0, lim, 1'b0, 32'h1234_5680);
        // Timeout boundary for an erase: 5 reads, latency 1 -> span 10
        for (int lim = 8; lim <= 10; lim++)
            run_op(1'b1, 1, 3, 1'b0, lim, 1'b0, 32'h0);
        // Device never completes
        run_op(1'b0, 1, 2000, 1'b0, 40, 1'b1, 32'h0F0F_0F0F);
        run_op(1'b1, 3, 2000, 1'b0, 25, 1'b0, 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule